// File: doc/BRIEF.md
# Triangular Spread-Spectrum Modulation Controller

This block produces the digital frequency profile for a center-spread clock. It runs on the reference clock. It sweeps a signed frequency-offset word linearly up to a positive extreme, down through zero to the mirrored negative extreme, and back to zero. One full sweep takes a fixed number of reference cycles, and a two-bit range select picks that number. A three-bit spread code sets the peak-to-peak deviation as a fraction of the nominal tuning word.

The offset is added to the nominal tuning word. The sum is the increment of a phase-accumulator NCO, which emits a one-cycle clock-enable pulse on every accumulator overflow. Downstream logic uses this pulse train as a frequency-modulated clock enable. Settings are taken only at the point where the offset climbs back to zero, so the frequency never jumps.

Top module: `ssc_mod_ctrl`

## Requirements
- R1: The sweep period in reference cycles follows `rng_sel`: 2'b00 gives 120, 2'b01 gives 240, 2'b10 gives 480 and 2'b11 gives 720.
- R2: The peak offset is floor(nom × (2 + c) / 400), where c is `spread_code` clamped to 6. Codes 0 to 6 give 1.0% to 4.0% total spread in 0.5% steps, and code 7 behaves as code 6.
- R3: The spread is centered. Within every sweep the largest offset is exactly +peak and the smallest is exactly −peak.
- R4: The sweep starts at 0 and rises for the first quarter. It first reaches +peak at sample period/4. Adjacent samples differ by at most ceil(4 × peak / period), and the offsets summed over one sweep give exactly 0.
- R5: A change of `rng_sel`, `spread_code` or `nom_tw` takes effect only on the sample where the offset returns to 0 from a negative value. A sweep already in progress finishes with its old period and peak.
- R6: Each cycle the NCO adds nom + offset (modulo 2^32) to its 32-bit accumulator. `clk_en` is high for one cycle, one cycle after each overflow. Over a whole sweep the pulse count is period × nom / 2^32 when that is an integer.
- R7: Synchronous active-low reset clears the offset and `clk_en` to 0 and starts the rising phase. The first sweep after reset uses period 480 and code 2, whatever the inputs are.
- R8: With code 2 the offset spans ±1% of the nominal word. For a 20 MHz nominal rate the output sweeps from 19.8 MHz to 20.2 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rng_sel | input | 2 | Sweep-period select |
| spread_code | input | 3 | Total spread select, 1.0% to 4.0% |
| nom_tw | input | 32 | Nominal NCO tuning word |
| freq_ofs | output | 28 | Signed frequency offset currently applied |
| clk_en | output | 1 | Modulated clock-enable pulse |

## Verification
The bench uses the default parameters: a 32-bit NCO, a 28-bit offset and the divisors 120, 240, 480 and 720. With these values all four sweep lengths complete within a few thousand cycles, so every mode's period, extremes, symmetry and step bound can be measured over whole sweeps. Nominal words such as 123457 and 999 leave a remainder when divided by the quarter period, which exercises the fractional stepping. A nominal word of 2^28 makes the pulse count over the 480- and 720-cycle sweeps an exact integer that the bench can predict.

// File: rtl/ssc_pkg.sv
// Shared types for the spread-spectrum modulation controller.
package ssc_pkg;

    // Quarter of the triangle currently being produced.
    typedef enum logic [1:0] {
        PH_RISE_A = 2'd0,   // 0 up to +peak
        PH_FALL_A = 2'd1,   // +peak down to 0
        PH_FALL_B = 2'd2,   // 0 down to -peak
        PH_RISE_B = 2'd3    // -peak up to 0
    } ssc_phase_e;

endpackage

// File: rtl/ssc_sel_decode.sv
// Select decoder: turns the range select, spread code and nominal word into
// a sweep period, a quarter period and a peak offset magnitude.
// Assumes each divisor is a multiple of four and SPAN_DEN is non-zero.
module ssc_sel_decode #(
    parameter int TW_W     = 32,
    parameter int MAG_W    = 27,
    parameter int PER_W    = 10,
    parameter int QTR_W    = 8,
    parameter int DIV_A    = 120,
    parameter int DIV_B    = 240,
    parameter int DIV_C    = 480,
    parameter int DIV_D    = 720,
    parameter int SPAN_DEN = 400,
    parameter int SPAN_BASE = 2,
    parameter int CODE_SAT = 6
) (
    input  logic [1:0]       sel,
    input  logic [2:0]       code,
    input  logic [TW_W-1:0]  nom,
    output logic [PER_W-1:0] per,
    output logic [QTR_W-1:0] qtr,
    output logic [MAG_W-1:0] peak
);
    localparam int PW = TW_W + 4;

    logic [2:0]    code_eff;
    logic [3:0]    factor;
    logic [PW-1:0] prod;
    logic [PW-1:0] quo;

    // Map the range select onto a sweep length.
    always_comb begin
        case (sel)
            2'b00:   per = PER_W'(DIV_A);
            2'b01:   per = PER_W'(DIV_B);
            2'b10:   per = PER_W'(DIV_C);
            default: per = PER_W'(DIV_D);
        endcase
        qtr = QTR_W'(per >> 2);
    end

    // Clamp the code and scale the nominal word into the peak magnitude.
    always_comb begin
        code_eff = (code > 3'(CODE_SAT)) ? 3'(CODE_SAT) : code;
        factor   = 4'(SPAN_BASE) + {1'b0, code_eff};
        prod     = PW'(nom) * PW'(factor);
        quo      = prod / PW'(SPAN_DEN);
        peak     = MAG_W'(quo);
    end

endmodule

// File: rtl/ssc_tri_seq.sv
// Triangle sequencer: holds the latched settings and steps a signed offset
// through four quarters. Within each quarter the magnitude is
// floor(peak*i/quarter), built from an integer step and a remainder
// accumulator, so the extremes are exact and nothing drifts.
// Settings load during reset and on the last sample of each sweep.
// Assumes the quarter length is at least one.
module ssc_tri_seq
    import ssc_pkg::*;
#(
    parameter int TW_W  = 32,
    parameter int OFS_W = 28,
    parameter int PER_W = 10,
    parameter int QTR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PER_W-1:0]        ld_per,
    input  logic [QTR_W-1:0]        ld_qtr,
    input  logic [OFS_W-2:0]        ld_peak,
    input  logic [TW_W-1:0]         ld_nom,
    output logic signed [OFS_W-1:0] ofs,
    output logic                    wrap,
    output logic [PER_W-1:0]        per_l,
    output logic [OFS_W-2:0]        peak_l,
    output logic [OFS_W-2:0]        step_q,
    output logic [TW_W-1:0]         nom_l
);
    localparam int MAG_W = OFS_W - 1;

    ssc_phase_e       ph;
    logic [QTR_W-1:0] idx;
    logic [QTR_W-1:0] rem;
    logic [QTR_W-1:0] qtr_l;
    logic [QTR_W-1:0] frac;
    logic [QTR_W:0]   rem_sum;
    logic [QTR_W-1:0] rem_nxt;
    logic [MAG_W-1:0] mag_acc;
    logic [MAG_W-1:0] mag_nxt;
    logic [MAG_W-1:0] mag;
    logic             neg;
    logic             last;
    logic             load;

    // Integer step and remainder of peak divided by the quarter length.
    always_comb begin
        step_q = peak_l / MAG_W'(qtr_l);
        frac   = QTR_W'(peak_l % MAG_W'(qtr_l));
    end

    // Next magnitude from step plus carried remainder.
    always_comb begin
        rem_sum = {1'b0, rem} + {1'b0, frac};
        if (rem_sum >= {1'b0, qtr_l}) begin
            rem_nxt = QTR_W'(rem_sum - {1'b0, qtr_l});
            mag_nxt = mag_acc + step_q + MAG_W'(1);
        end else begin
            rem_nxt = QTR_W'(rem_sum);
            mag_nxt = mag_acc + step_q;
        end
    end

    // End-of-quarter and end-of-sweep detection.
    always_comb begin
        last = (idx == qtr_l - QTR_W'(1));
        wrap = last && (ph == PH_RISE_B);
        load = !rst_n || wrap;
    end

    // Signed offset from quarter and magnitude.
    always_comb begin
        case (ph)
            PH_RISE_A: begin mag = mag_acc;          neg = 1'b0; end
            PH_FALL_A: begin mag = peak_l - mag_acc; neg = 1'b0; end
            PH_FALL_B: begin mag = mag_acc;          neg = 1'b1; end
            default:   begin mag = peak_l - mag_acc; neg = 1'b1; end
        endcase
        ofs = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end

    // Latch settings in reset and at the sweep boundary only.
    always_ff @(posedge clk) begin
        if (load) begin
            per_l  <= ld_per;
            qtr_l  <= ld_qtr;
            peak_l <= ld_peak;
            nom_l  <= ld_nom;
        end
    end

    // Advance the quarter, the index and the magnitude accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= PH_RISE_A;
            idx     <= '0;
            mag_acc <= '0;
            rem     <= '0;
        end else if (last) begin
            ph      <= ssc_phase_e'(ph + 2'd1);
            idx     <= '0;
            mag_acc <= '0;
            rem     <= '0;
        end else begin
            idx     <= idx + QTR_W'(1);
            mag_acc <= mag_nxt;
            rem     <= rem_nxt;
        end
    end

endmodule

// File: rtl/ssc_nco.sv
// Phase-accumulator NCO: adds nominal word plus signed offset every cycle
// and registers the carry as a one-cycle enable pulse.
// Assumes nom plus the offset stays below 2^TW_W.
module ssc_nco #(
    parameter int TW_W  = 32,
    parameter int OFS_W = 28
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [TW_W-1:0]         nom,
    input  logic signed [OFS_W-1:0] ofs,
    output logic                    tick
);
    logic [TW_W-1:0] acc;
    logic [TW_W:0]   inc;
    logic [TW_W:0]   sum;

    // Form the increment and the next accumulator value.
    always_comb begin
        inc = {1'b0, nom} + {{(TW_W + 1 - OFS_W){ofs[OFS_W-1]}}, ofs};
        sum = {1'b0, acc} + {1'b0, inc[TW_W-1:0]};
    end

    // Accumulate and register the overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            tick <= 1'b0;
        end else begin
            acc  <= sum[TW_W-1:0];
            tick <= sum[TW_W];
        end
    end

endmodule

// File: rtl/ssc_mod_ctrl.sv
// Spread-spectrum modulation controller top. Decodes the settings (forced to
// the reset defaults while reset is low), runs the triangle sequencer and
// drives the NCO. Divisors must be multiples of four.
module ssc_mod_ctrl #(
    parameter int         TW_W      = 32,
    parameter int         DIV_A     = 120,
    parameter int         DIV_B     = 240,
    parameter int         DIV_C     = 480,
    parameter int         DIV_D     = 720,
    parameter int         SPAN_DEN  = 400,
    parameter int         SPAN_BASE = 2,
    parameter int         CODE_SAT  = 6,
    parameter logic [1:0] RST_SEL   = 2'b10,
    parameter logic [2:0] RST_CODE  = 3'd2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             rng_sel,
    input  logic [2:0]             spread_code,
    input  logic [TW_W-1:0]        nom_tw,
    output logic signed [TW_W-5:0] freq_ofs,
    output logic                   clk_en
);
    localparam int OFS_W   = TW_W - 4;
    localparam int MAG_W   = OFS_W - 1;
    localparam int PER_W   = $clog2(DIV_D + 1);
    localparam int QTR_W   = $clog2(DIV_D / 4 + 1);
    localparam int RST_PER = (RST_SEL == 2'b00) ? DIV_A :
                             (RST_SEL == 2'b01) ? DIV_B :
                             (RST_SEL == 2'b10) ? DIV_C : DIV_D;

    logic [1:0]       sel_eff;
    logic [2:0]       code_in;
    logic [PER_W-1:0] dec_per;
    logic [QTR_W-1:0] dec_qtr;
    logic [MAG_W-1:0] dec_peak;
    logic             wrap;
    logic [PER_W-1:0] per_l;
    logic [MAG_W-1:0] peak_l;
    logic [MAG_W-1:0] step_q;
    logic [TW_W-1:0]  nom_l;

    // Reset forces the default mode into the decoder.
    always_comb begin
        sel_eff = rst_n ? rng_sel     : RST_SEL;
        code_in = rst_n ? spread_code : RST_CODE;
    end

    ssc_sel_decode #(
        .TW_W(TW_W), .MAG_W(MAG_W), .PER_W(PER_W), .QTR_W(QTR_W),
        .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C), .DIV_D(DIV_D),
        .SPAN_DEN(SPAN_DEN), .SPAN_BASE(SPAN_BASE), .CODE_SAT(CODE_SAT)
    ) u_dec (
        .sel(sel_eff), .code(code_in), .nom(nom_tw),
        .per(dec_per), .qtr(dec_qtr), .peak(dec_peak)
    );

    ssc_tri_seq #(
        .TW_W(TW_W), .OFS_W(OFS_W), .PER_W(PER_W), .QTR_W(QTR_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .ld_per(dec_per), .ld_qtr(dec_qtr), .ld_peak(dec_peak), .ld_nom(nom_tw),
        .ofs(freq_ofs), .wrap(wrap), .per_l(per_l), .peak_l(peak_l),
        .step_q(step_q), .nom_l(nom_l)
    );

    ssc_nco #(
        .TW_W(TW_W), .OFS_W(OFS_W)
    ) u_nco (
        .clk(clk), .rst_n(rst_n), .nom(nom_l), .ofs(freq_ofs), .tick(clk_en)
    );

endmodule

// File: rtl/ssc_mod_ctrl_chk.sv
// Assertion checker for ssc_mod_ctrl, attached by bind below.
module ssc_mod_ctrl_chk #(
    parameter int TW_W    = 32,
    parameter int OFS_W   = 28,
    parameter int PER_W   = 10,
    parameter int RST_PER = 480
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    clk_en,
    input logic signed [OFS_W-1:0] ofs,
    input logic                    wrap,
    input logic [PER_W-1:0]        per_l,
    input logic [OFS_W-2:0]        peak_l,
    input logic [OFS_W-2:0]        step_q,
    input logic [TW_W-1:0]         nom_l
);
    logic                    started;
    logic [PER_W-1:0]        cyc;
    logic signed [OFS_W-1:0] prev_ofs;
    logic [OFS_W-2:0]        prev_step;
    logic signed [OFS_W:0]   dlt;
    logic [OFS_W:0]          adlt;

    // Track time since reset, sweep position and the previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started   <= 1'b0;
            cyc       <= '0;
            prev_ofs  <= '0;
            prev_step <= '0;
        end else begin
            started   <= 1'b1;
            cyc       <= wrap ? '0 : cyc + PER_W'(1);
            prev_ofs  <= ofs;
            prev_step <= step_q;
        end
    end

    // Absolute change between adjacent samples.
    always_comb begin
        dlt  = $signed({ofs[OFS_W-1], ofs}) - $signed({prev_ofs[OFS_W-1], prev_ofs});
        adlt = dlt[OFS_W] ? OFS_W'(0) - dlt : dlt;
    end

    assert_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> (cyc == per_l - PER_W'(1)));

    assert_ofs_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(ofs) <= $signed({1'b0, peak_l})) && ($signed(ofs) >= -$signed({1'b0, peak_l})));

    assert_step_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (adlt <= {2'b00, prev_step} + (OFS_W+1)'(1)));

    assert_after_peak_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs == $signed({1'b0, peak_l})) |=> ($signed(ofs) <= $past($signed(ofs))));

    assert_hold_setting_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (started && !$past(wrap)) |-> ($stable(peak_l) && $stable(per_l)));

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && nom_l[TW_W-1:TW_W-2] == 2'b00) |=> !clk_en);

    assert_reset_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !started |-> (ofs == '0 && !clk_en && per_l == PER_W'(RST_PER)));

endmodule

bind ssc_mod_ctrl ssc_mod_ctrl_chk #(
    .TW_W(TW_W), .OFS_W(OFS_W), .PER_W(PER_W), .RST_PER(RST_PER)
) u_chk (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ofs(freq_ofs), .wrap(wrap),
    .per_l(per_l), .peak_l(peak_l), .step_q(step_q), .nom_l(nom_l)
);

// File: tb/sim_ssc_mod_ctrl.sv
module sim_ssc_mod_ctrl;

    typedef struct packed {
        logic [1:0]  sel;
        logic [2:0]  code;
        logic [31:0] nom;
        logic [15:0] per;
    } vec_t;

    // rng_sel, spread_code, nominal word, expected sweep length (R1)
    localparam vec_t VECS [6] = '{
        '{2'b00, 3'd0, 32'd400000, 16'd120},
        '{2'b01, 3'd3, 32'd400000, 16'd240},
        '{2'b10, 3'd7, 32'd400000, 16'd480},
        '{2'b11, 3'd6, 32'd400000, 16'd720},
        '{2'b11, 3'd1, 32'd123457, 16'd720},
        '{2'b00, 3'd5, 32'd999,    16'd120}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        rng_sel = 2'b00;
    logic [2:0]        spread_code = 3'd6;
    logic [31:0]       nom_tw = 32'd400000;
    logic signed [27:0] freq_ofs;
    logic              clk_en;

    int     checks = 0;
    int     errors = 0;
    bit     done = 1'b0;
    longint cur = 0;
    longint prv = 0;

    always #4ns clk = ~clk;

    ssc_mod_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .rng_sel(rng_sel), .spread_code(spread_code),
        .nom_tw(nom_tw), .freq_ofs(freq_ofs), .clk_en(clk_en)
    );

    // Peak from R2: floor(nom*(2+min(code,6))/400)
    function automatic longint exp_peak(longint nom, int code);
        int c = (code > 6) ? 6 : code;
        return (nom * (2 + c)) / 400;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        prv = cur;
        cur = longint'(freq_ofs);
    endtask

    function automatic bit rising();
        return (cur == 0) && (prv < 0);
    endfunction

    task automatic wait_rise();
        for (int n = 0; n < 3000; n++) begin
            step();
            if (rising()) break;
        end
    endtask

    // Measure one sweep starting at the current sample; ends on the next rise.
    task automatic measure(output longint per, output longint mx, output longint mn,
                           output longint sm, output longint mxat, output longint mxd);
        longint d;
        per = 1; mx = cur; mn = cur; sm = cur; mxat = 0; mxd = 0;
        for (int n = 0; n < 3000; n++) begin
            step();
            if (rising()) break;
            d = (cur > prv) ? cur - prv : prv - cur;
            if (d > mxd) mxd = d;
            if (cur > mx) begin mx = cur; mxat = per; end
            if (cur < mn) mn = cur;
            sm += cur;
            per++;
        end
    endtask

    initial begin
        longint per, mx, mn, sm, mxat, mxd, pk, q, pulses;
        // Reset held with non-default inputs (R7)
        repeat (4) @(posedge clk);
        @(negedge clk);
        cur = longint'(freq_ofs); prv = 0;
        chk(freq_ofs == 0, "R7 offset in reset", cur, 0);
        chk(clk_en == 1'b0, "R7 clk_en in reset", longint'(clk_en), 0);
        rst_n = 1'b1;
        // First sweep: defaults 480 cycles, code 2 => +/-1% of nominal (R7, R8)
        measure(per, mx, mn, sm, mxat, mxd);
        chk(per == 480, "R7 first sweep period", per, 480);
        chk(mx == 4000, "R8 first sweep +1% peak", mx, 4000);
        chk(mn == -4000, "R8 first sweep -1% peak", mn, -4000);
        // Second sweep picks up rng_sel=00 and code 6 (R1, R2)
        measure(per, mx, mn, sm, mxat, mxd);
        chk(per == 120, "R1 period after reset sweep", per, 120);
        chk(mx == exp_peak(400000, 6), "R2 peak code 6", mx, exp_peak(400000, 6));

        // Table walk: every range mode and several codes
        foreach (VECS[i]) begin
            rng_sel = VECS[i].sel;
            spread_code = VECS[i].code;
            nom_tw = VECS[i].nom;
            wait_rise();
            measure(per, mx, mn, sm, mxat, mxd);
            pk = exp_peak(longint'(VECS[i].nom), int'(VECS[i].code));
            q = longint'(VECS[i].per) / 4;
            chk(per == longint'(VECS[i].per), "R1 sweep period", per, longint'(VECS[i].per));
            chk(mx == pk, "R2 R3 positive extreme", mx, pk);
            chk(mn == -pk, "R3 negative extreme", mn, -pk);
            chk(sm == 0, "R4 zero sum over sweep", sm, 0);
            chk(mxat == q, "R4 first peak at quarter", mxat, q);
            chk(mxd <= (pk + q - 1) / q, "R4 step bound", mxd, (pk + q - 1) / q);
        end

        // Settings changed one cycle into a sweep must wait (R5)
        rng_sel = 2'b00; spread_code = 3'd0; nom_tw = 32'd400000;
        wait_rise();
        rng_sel = 2'b01; spread_code = 3'd6;
        measure(per, mx, mn, sm, mxat, mxd);
        chk(per == 120, "R5 running sweep keeps period", per, 120);
        chk(mx == 2000, "R5 running sweep keeps peak", mx, 2000);
        measure(per, mx, mn, sm, mxat, mxd);
        chk(per == 240, "R5 new period at boundary", per, 240);
        chk(mx == 8000, "R5 new peak at boundary", mx, 8000);

        // NCO pulse count over whole sweeps with nom = 2^28 (R6)
        rng_sel = 2'b10; spread_code = 3'd0; nom_tw = 32'h1000_0000;
        wait_rise();
        pulses = 0;
        for (int n = 0; n < 480; n++) begin
            step();
            pulses += longint'(clk_en);
        end
        chk(pulses == 30, "R6 pulses over 480-cycle sweep", pulses, 30);
        rng_sel = 2'b11; spread_code = 3'd4;
        wait_rise();
        pulses = 0;
        for (int n = 0; n < 720; n++) begin
            step();
            pulses += longint'(clk_en);
        end
        chk(pulses == 45, "R6 pulses over 720-cycle sweep", pulses, 45);

        // Reset in mid-sweep returns to zero and default mode (R7)
        repeat (37) step();
        rst_n = 1'b0;
        repeat (2) step();
        chk(freq_ofs == 0, "R7 offset after mid-sweep reset", cur, 0);
        rst_n = 1'b1;
        measure(per, mx, mn, sm, mxat, mxd);
        chk(per == 480, "R7 default period after reset", per, 480);
        chk(mx == exp_peak(32'h1000_0000, 2), "R7 default code after reset", mx,
            exp_peak(32'h1000_0000, 2));

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule